// File: doc/BRIEF.md
# Seek-Addressed Persistent Byte Store with Direct RAM

This block is a pair of 256-byte memories, 8 bits wide, that share one store/load interface. A mode input chooses which memory serves the access. In direct mode the operand is an absolute address into a scratch RAM. In persistent mode the operand is a seek distance. The access uses an internal pointer, and once it completes the pointer moves forward by the operand, modulo 256.

A processor core drives the block. A run of persistent-mode stores with seek 1 lays bytes down one after another. A later run of loads with seek 1 streams them back in the same order. The persistent array is cleared only by a dedicated power-on clear, so its data survives the CPU reset. The CPU reset zeroes the direct RAM and returns the seek pointer to 0.

Top module: `seek_store_mem`

## Requirements
- R1: A load that is not paired with a store returns its byte on `rdData` after the next rising clock edge. In any cycle without such a load, `rdData` keeps its value.
- R2: When `persistMode` is 0, a store writes `wrData` to RAM location `addrSeek` and a load reads that location. Accesses in one mode never write the other memory and never move the seek pointer.
- R3: When `persistMode` is 1, a store writes `wrData` at the seek pointer and then sets the pointer to pointer + `addrSeek`. For example, from pointer 0, stores of 42/seek 1, 57/seek 2 and 99/seek 3 fill locations 0, 1 and 3 and leave the pointer at 6.
- R4: When `persistMode` is 1, a load reads the byte at the seek pointer and then advances the pointer by `addrSeek`. A seek of 0 reads the same byte again.
- R5: The seek pointer wraps modulo 256. From pointer 6, a seek of 250 gives pointer 0.
- R6: With `rstN` low, `rdData` goes to 0, the seek pointer goes to 0 and every RAM byte goes to 0. The persistent array is left unchanged.
- R7: With `porN` low, every persistent byte goes to 0 and the seek pointer goes to 0.
- R8: When `storeEn` and `loadEn` are high in the same cycle, only the store takes place, and `rdData` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low CPU reset |
| porN | input | 1 | Synchronous active-low power-on clear of the persistent array |
| persistMode | input | 1 | 1 selects the seek-addressed persistent store, 0 the direct RAM |
| storeEn | input | 1 | Store strobe |
| loadEn | input | 1 | Load strobe |
| wrData | input | 8 | Byte to store |
| addrSeek | input | 8 | RAM address in direct mode, seek distance in persistent mode |
| rdData | output | 8 | Registered load result |

## Verification
A load result appears on `rdData` after the rising edge that samples the load strobe, so it is due one cycle after the strobe. Every check waits for that edge, steps a short time past it, and only then compares. Stores, pointer moves and resets take effect at that same edge. Their results are observed through the first later load, which reports one cycle after its own strobe. The only exception is the reset value of `rdData`, which is read directly while reset is held.

// File: rtl/seek_store_pkg.sv
package seek_store_pkg;
  typedef struct packed {
    logic ramWr;
    logic pstWr;
    logic rdLatch;
    logic rdSelPst;
    logic ptrAdv;
  } ctlStrobes_t;
endpackage

// File: rtl/seek_store_bank.sv
module seek_store_bank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              clrEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrWord,
  output logic [DATA_W-1:0] rdWord
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (clrEn) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[addr] <= wrWord;
    end
  end

  assign rdWord = mem[addr];
endmodule

// File: rtl/seek_store_ctrl.sv
module seek_store_ctrl
  import seek_store_pkg::*;
(
  input  logic        persistMode,
  input  logic        storeEn,
  input  logic        loadEn,
  output ctlStrobes_t ctl
);
  logic doStore;
  logic doLoad;

  // a store wins over a simultaneous load
  assign doStore = storeEn;
  assign doLoad  = loadEn && !storeEn;

  always_comb begin
    ctl.ramWr    = doStore && !persistMode;
    ctl.pstWr    = doStore && persistMode;
    ctl.rdLatch  = doLoad;
    ctl.rdSelPst = persistMode;
    ctl.ptrAdv   = persistMode && (doStore || doLoad);
  end
endmodule

// File: rtl/seek_store_path.sv
module seek_store_path
  import seek_store_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addrSeek,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] ramWord;
  logic [DATA_W-1:0] pstWord;

  seek_store_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .clrEn(!rstN), .wrEn(ctl.ramWr), .addr(addrSeek),
    .wrWord(wrData), .rdWord(ramWord)
  );

  seek_store_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pst (
    .clk(clk), .clrEn(!porN), .wrEn(ctl.pstWr), .addr(ptr),
    .wrWord(wrData), .rdWord(pstWord)
  );

  always_ff @(posedge clk) begin
    if (!rstN || !porN) ptr <= '0;
    else if (ctl.ptrAdv) ptr <= ptr + addrSeek;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (ctl.rdLatch) rdData <= ctl.rdSelPst ? pstWord : ramWord;
  end
endmodule

// File: rtl/seek_store_mem.sv
module seek_store_mem
  import seek_store_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              persistMode,
  input  logic              storeEn,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addrSeek,
  output logic [DATA_W-1:0] rdData
);
  ctlStrobes_t ctl;

  seek_store_ctrl u_ctrl (
    .persistMode(persistMode), .storeEn(storeEn), .loadEn(loadEn), .ctl(ctl)
  );

  seek_store_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rstN(rstN), .porN(porN), .ctl(ctl),
    .wrData(wrData), .addrSeek(addrSeek), .rdData(rdData)
  );
endmodule

// File: rtl/seek_store_chk.sv
module seek_store_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              porN,
  input logic              persistMode,
  input logic              storeEn,
  input logic              loadEn,
  input logic [ADDR_W-1:0] addrSeek,
  input logic [ADDR_W-1:0] ptr,
  input logic [DATA_W-1:0] rdData
);
  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(loadEn && !storeEn) |=> $stable(rdData));

  assert_rd_hold_on_collide_R8: assert property (@(posedge clk) disable iff (!rstN)
    (storeEn && loadEn) |=> $stable(rdData));

  assert_reset_rd_zero_R6: assert property (@(posedge clk)
    !rstN |=> rdData == '0);

  assert_ptr_store_advance_R3: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (persistMode && storeEn) |=> ptr == ADDR_W'($past(ptr) + $past(addrSeek)));

  assert_ptr_load_advance_R4: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (persistMode && loadEn && !storeEn) |=> ptr == ADDR_W'($past(ptr) + $past(addrSeek)));

  assert_ptr_still_in_ram_mode_R2: assert property (@(posedge clk) disable iff (!rstN || !porN)
    !persistMode |=> $stable(ptr));

  assert_por_ptr_zero_R7: assert property (@(posedge clk)
    !porN |=> ptr == '0);
endmodule

bind seek_store_mem seek_store_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .porN(porN), .persistMode(persistMode),
  .storeEn(storeEn), .loadEn(loadEn), .addrSeek(addrSeek),
  .ptr(u_path.ptr), .rdData(rdData)
);

// File: tb/seek_store_mem_tb.sv
module seek_store_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  logic       clk = 0;
  logic       rstN = 0;
  logic       porN = 0;
  logic       persistMode = 0;
  logic       storeEn = 0;
  logic       loadEn = 0;
  logic [7:0] wrData = 0;
  logic [7:0] addrSeek = 0;
  logic [7:0] rdData;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seek_store_mem u_dut (
    .clk(clk), .rstN(rstN), .porN(porN), .persistMode(persistMode),
    .storeEn(storeEn), .loadEn(loadEn), .wrData(wrData),
    .addrSeek(addrSeek), .rdData(rdData)
  );

  // {req[3:0], mode, st, ld, wd[7:0], seek[7:0], chk, exp[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd3, 1'b1, 1'b1, 1'b0, 8'd42,  8'd1,   1'b0, 8'd0},   // R3 ptr 0->1
    {4'd3, 1'b1, 1'b1, 1'b0, 8'd57,  8'd2,   1'b0, 8'd0},   // R3 ptr 1->3
    {4'd3, 1'b1, 1'b1, 1'b0, 8'd99,  8'd3,   1'b0, 8'd0},   // R3 ptr 3->6
    {4'd2, 1'b0, 1'b1, 1'b0, 8'hAA,  8'd0,   1'b0, 8'd0},   // R2 RAM[0]
    {4'd1, 1'b0, 1'b0, 1'b1, 8'd0,   8'd0,   1'b1, 8'hAA},  // R1 RAM read
    {4'd2, 1'b0, 1'b0, 1'b1, 8'd0,   8'd3,   1'b1, 8'd0},   // R2 RAM[3] untouched
    {4'd2, 1'b0, 1'b1, 1'b0, 8'h11,  8'd1,   1'b0, 8'd0},   // R2 RAM[1]
    {4'd5, 1'b1, 1'b0, 1'b1, 8'd0,   8'd250, 1'b1, 8'd0},   // R5 ptr 6->0
    {4'd4, 1'b1, 1'b0, 1'b1, 8'd0,   8'd1,   1'b1, 8'd42},  // R4 ptr 0->1
    {4'd4, 1'b1, 1'b0, 1'b1, 8'd0,   8'd0,   1'b1, 8'd57},  // R4 seek 0
    {4'd3, 1'b1, 1'b0, 1'b1, 8'd0,   8'd2,   1'b1, 8'd57},  // R3 ptr 1->3
    {4'd3, 1'b1, 1'b0, 1'b1, 8'd0,   8'd3,   1'b1, 8'd99},  // R3 ptr 3->6
    {4'd8, 1'b1, 1'b1, 1'b1, 8'd77,  8'd2,   1'b1, 8'd99},  // R8 store wins
    {4'd5, 1'b1, 1'b0, 1'b1, 8'd0,   8'd254, 1'b1, 8'd0},   // R5 ptr 8->6
    {4'd8, 1'b1, 1'b0, 1'b1, 8'd0,   8'd0,   1'b1, 8'd77}   // R8 store landed
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL R%0d: rdData=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int req, input logic m, input logic st, input logic ld,
                      input logic [7:0] wd, input logic [7:0] sk,
                      input logic chk, input logic [7:0] exp);
    @(negedge clk);
    persistMode = m; storeEn = st; loadEn = ld; wrData = wd; addrSeek = sk;
    @(posedge clk);
    #1;
    storeEn = 0; loadEn = 0;
    if (chk) check(req, rdData, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    porN = 1; rstN = 1;

    for (int i = 0; i < NVEC; i++) begin
      step(int'(VEC[i][31:28]), VEC[i][27], VEC[i][26], VEC[i][25],
           VEC[i][24:17], VEC[i][16:9], VEC[i][8], VEC[i][7:0]);
    end

    // R6: CPU reset clears rdData, RAM, pointer; keeps persistent array
    @(negedge clk); rstN = 0;
    @(posedge clk); #1;
    check(6, rdData, 8'd0);
    @(negedge clk); rstN = 1;
    step(6, 1'b0, 1'b0, 1'b1, 8'd0, 8'd0, 1'b1, 8'd0);   // R6 RAM[0] zeroed
    step(6, 1'b1, 1'b0, 1'b1, 8'd0, 8'd1, 1'b1, 8'd42);  // R6 ptr 0, data kept
    // R1: idle cycle holds rdData
    step(1, 1'b1, 1'b0, 1'b0, 8'd0, 8'd5, 1'b1, 8'd42);

    // R7: power-on clear zeroes persistent array and pointer
    @(negedge clk); porN = 0;
    @(posedge clk);
    @(negedge clk); porN = 1;
    step(7, 1'b1, 1'b0, 1'b1, 8'd0, 8'd0, 1'b1, 8'd0);   // R7 location 0 cleared
    step(7, 1'b1, 1'b1, 1'b0, 8'd5, 8'd1, 1'b0, 8'd0);
    step(7, 1'b1, 1'b0, 1'b1, 8'd0, 8'd255, 1'b1, 8'd0); // R7 location 1 cleared
    step(7, 1'b1, 1'b0, 1'b1, 8'd0, 8'd0, 1'b1, 8'd5);   // R7 pointer restarted at 0

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule